// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external microcontroller reach a bank of 32 eight-bit control registers over a four-wire serial link. The link has a chip select, a serial clock, serial data in and serial data out. The core side sees a plain register-file interface: an address, a one-clock write strobe with write data, and a combinational read-data return. The block frames transfers and decodes commands. The register contents and their meaning are left to the core.

A transfer starts when chip select falls. The next eight serial clocks carry a command byte made of a read/write flag and a five-bit register address. Every byte after that is data for that one address, until chip select rises. Incoming bits are captured on rising serial-clock edges and outgoing bits change after falling edges. A static mode input chooses whether bytes travel most-significant bit first or least-significant bit first.

All four link pins are sampled with a system clock that runs at least four times faster than the serial clock. Chip select, serial clock and data in pass through two-flop synchronizers before edge detection.

Top module: `ser_regport`

## Requirements
- R1: After reset, reg_wr is 0, sdo_oe is 0 and sdo is 0.
- R2: The first eight serial clocks after chip select falls form the command byte. In its assembled form, bit 7 is the direction (1 = read, 0 = write), bits 6:5 are ignored, and bits 4:0 are the register address. reg_addr takes that address when the command byte completes and holds it for the rest of the transfer.
- R3: In a write transfer, each complete data byte produces exactly one system-clock pulse on reg_wr. During that pulse, reg_wdata carries the byte and reg_addr carries the commanded address.
- R4: With lsb_first = 0, every byte is shifted most-significant bit first, in both directions.
- R5: With lsb_first = 1, every byte is shifted least-significant bit first, in both directions. The assembled field positions of R2 are unchanged.
- R6: In a read transfer, sdo presents reg_rdata of the commanded address in the selected bit order. The first bit is valid before the first data rising edge, and each later bit changes after a falling serial-clock edge.
- R7: During a read transfer, data shifted in on sdi is ignored and reg_wr stays 0.
- R8: While chip select stays low, every byte after the command byte is data for the same address, even when it looks like a command. Writes produce one strobe per byte, and reads return the register again for each byte. A new command is taken only after chip select goes high and then low.
- R9: If chip select rises before a data byte is complete, or before the command byte is complete, no write takes place.
- R10: sdo_oe is 1 only while chip select is low. sdo is 0 one system clock after sdo_oe drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsb_first | input | 1 | Static framing mode: 1 = LSB first, 0 = MSB first |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the microcontroller, idles low |
| sdi | input | 1 | Serial data from the microcontroller |
| sdo | output | 1 | Serial data to the microcontroller |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| reg_addr | output | 5 | Register address toward the core |
| reg_wr | output | 1 | One-clock write strobe toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_rdata | input | 8 | Read data from the core for reg_addr |

## Verification
The hardest case to reach from the ports is a chip select that rises part-way through a byte. A plain byte-level driver never produces it. The bench therefore uses a bit-level task that stops after a chosen number of serial clocks, in both the command phase and the data phase. It then shows that no write strobe appeared and that a full transfer right afterwards still decodes correctly. Multi-byte bursts with a data byte shaped like a read command show that the port does not re-enter command decoding without a chip-select cycle.

// File: rtl/regport_pkg.sv
// Shared types for the serial register-access port.
package regport_pkg;
    // Transfer phase: waiting for select, collecting the command, moving data.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/regport_sync.sv
// Multi-bit level synchronizer.
// What it does: passes each input bit through a chain of STAGES flops.
// Assumes: the bits are independent and slow against clk; STAGES >= 2.
module regport_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/regport_frame.sv
// Receive framing and command decode.
// What it does: counts serial bits, assembles bytes in the chosen order,
// decodes the command byte and issues write strobes for complete data bytes.
// Assumes: edge pulses are one clk wide and come from synchronized signals;
// the direction flag sits in the top bit and the address in the low bits.
module regport_frame
    import regport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              cs_act,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              sdi_bit,
    output logic              rd_active,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int           RW_POS   = DATA_W - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-1:0]   shreg_q;
    logic [DATA_W-1:0]   shifted;
    logic                rw_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                wr_q;
    logic [DATA_W-1:0]   wdata_q;

    // Next shift-register value with the sampled bit inserted per mode.
    always_comb begin
        if (lsb_first) shifted = {sdi_bit, shreg_q[DATA_W-1:1]};
        else           shifted = {shreg_q[DATA_W-2:0], sdi_bit};
    end

    // Phase control, bit counting, command capture and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            wr_q <= 1'b0;
            if (cs_fall) begin
                phase_q <= PH_CMD;
                cnt_q   <= '0;
            end else if (!cs_act) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end else if (sclk_rise && phase_q != PH_IDLE) begin
                shreg_q <= shifted;
                if (cnt_q == LAST_BIT) begin
                    cnt_q <= '0;
                    if (phase_q == PH_CMD) begin
                        rw_q    <= shifted[RW_POS];
                        addr_q  <= shifted[ADDR_W-1:0];
                        phase_q <= PH_DATA;
                    end else if (!rw_q) begin
                        wr_q    <= 1'b1;
                        wdata_q <= shifted;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign rd_active = (phase_q == PH_DATA) && rw_q;
    assign bit_cnt   = cnt_q;
    assign reg_addr  = addr_q;
    assign reg_wr    = wr_q;
    assign reg_wdata = wdata_q;

    // R3
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R9
    wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(cs_act));

    // R7
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> !reg_wr);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && $past(phase_q) == PH_DATA) |-> $stable(reg_addr));
endmodule

// File: rtl/regport_txbit.sv
// Serial output driver.
// What it does: on each falling serial-clock edge of a read transfer,
// drives the bit of reg_rdata that the receive counter points at.
// Assumes: read data is valid from the command completion onward and
// stays stable during the transfer.
module regport_txbit #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              rd_active,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [CNT_W-1:0] idx;
    logic             sdo_q;

    // Pick the outgoing bit position from the count and the mode.
    always_comb begin
        if (lsb_first) idx = bit_cnt;
        else           idx = CNT_W'(DATA_W - 1) - bit_cnt;
    end

    // Update the serial output after falling edges; clear it when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sdo_q <= 1'b0;
        else if (!cs_act)                sdo_q <= 1'b0;
        else if (sclk_fall && rd_active) sdo_q <= rdata[idx];
    end

    assign sdo    = sdo_q;
    assign sdo_oe = cs_act;

    // R10
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |=> !sdo);
endmodule

// File: rtl/ser_regport.sv
// Serial register-access slave port (top).
// What it does: synchronizes the link pins, detects their edges and
// connects the framing and output-driver blocks to the register interface.
// Assumes: clk is at least 4x sclk; lsb_first changes only while deselected;
// sclk idles low.
module ser_regport #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [2:0]       pins_s;
    logic             cs_n_s, sclk_s, sdi_s;
    logic             cs_n_d, sclk_d;
    logic             cs_act, cs_fall, sclk_rise, sclk_fall;
    logic             rd_active;
    logic [CNT_W-1:0] bit_cnt;

    regport_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdi}),
        .dout  (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    // Delay the synchronized select and clock by one clk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_act    = !cs_n_s;
    assign cs_fall   = cs_n_d && !cs_n_s;
    assign sclk_rise = sclk_s && !sclk_d;
    assign sclk_fall = !sclk_s && sclk_d;

    regport_frame #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (lsb_first),
        .cs_act    (cs_act),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .sdi_bit   (sdi_s),
        .rd_active (rd_active),
        .bit_cnt   (bit_cnt),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

    regport_txbit #(
        .DATA_W (DATA_W)
    ) u_txbit (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (lsb_first),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .rd_active (rd_active),
        .bit_cnt   (bit_cnt),
        .rdata     (reg_rdata),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );
endmodule

// File: tb/ser_regport_bench.sv
`timescale 1ns/1ps
module ser_regport_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsb_first = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int wr_long = 0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_prev = 1'b0;

    always #2 clk = ~clk;

    ser_regport u_ser_regport (
        .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first), .cs_n(cs_n),
        .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] model_rd(input logic [4:0] a);
        return {a, 3'b000} ^ 8'hA5;
    endfunction

    assign reg_rdata = model_rd(reg_addr);

    // Record write strobes as the core would see them.
    always @(posedge clk) begin
        if (rst_n && reg_wr) begin
            wr_cnt++;
            wr_addr = reg_addr;
            wr_data = reg_wdata;
            if (wr_prev) wr_long++;
        end
        wr_prev = reg_wr;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cmd(input logic rd, input logic [1:0] junk,
                                          input logic [4:0] a);
        return {rd, junk, a};
    endfunction

    task automatic sel_on();
        cs_n = 1'b0;
        #64;
    endtask

    task automatic sel_off();
        #32;
        cs_n = 1'b1;
        #96;
    endtask

    task automatic one_bit(input logic b, output logic so);
        sdi = b;
        #32;
        so = sdo;
        sclk = 1'b1;
        #32;
        sclk = 1'b0;
    endtask

    // Shift up to nbits of a byte in the current mode; returns captured sdo.
    task automatic shift_bits(input logic [7:0] tx, input int nbits,
                              output logic [7:0] rx);
        logic b;
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            int idx = lsb_first ? i : 7 - i;
            one_bit(tx[idx], b);
            rx[idx] = b;
        end
    endtask

    task automatic t_reset();
        chk("R1 reg_wr", int'(reg_wr), 0);
        chk("R1 sdo_oe", int'(sdo_oe), 0);
        chk("R1 sdo", int'(sdo), 0);
    endtask

    task automatic t_write(input logic lsb, input logic [4:0] a, input logic [7:0] d,
                           input string tag);
        logic [7:0] rx;
        int n0 = wr_cnt;
        lsb_first = lsb;
        sel_on();
        shift_bits(mk_cmd(1'b0, 2'b11, a), 8, rx);
        shift_bits(d, 8, rx);
        sel_off();
        chk({tag, " R3 strobe count"}, wr_cnt - n0, 1);
        chk({tag, " R2 address"}, int'(wr_addr), int'(a));
        chk({tag, " R3 data"}, int'(wr_data), int'(d));
    endtask

    task automatic t_read(input logic lsb, input logic [4:0] a, input string tag);
        logic [7:0] rx;
        int n0 = wr_cnt;
        lsb_first = lsb;
        sel_on();
        chk({tag, " R10 oe while selected"}, int'(sdo_oe), 1);
        shift_bits(mk_cmd(1'b1, 2'b01, a), 8, rx);
        chk({tag, " R2 reg_addr"}, int'(reg_addr), int'(a));
        shift_bits(8'hFF, 8, rx);
        sel_off();
        chk({tag, " R6 read data"}, int'(rx), int'(model_rd(a)));
        chk({tag, " R7 no write"}, wr_cnt - n0, 0);
        chk({tag, " R10 oe off"}, int'(sdo_oe), 0);
        chk({tag, " R10 sdo low"}, int'(sdo), 0);
    endtask

    task automatic t_burst_write();
        logic [7:0] rx;
        int n0 = wr_cnt;
        lsb_first = 1'b0;
        sel_on();
        shift_bits(mk_cmd(1'b0, 2'b00, 5'h05), 8, rx);
        shift_bits(8'h11, 8, rx);
        shift_bits(mk_cmd(1'b1, 2'b00, 5'h1F), 8, rx);
        shift_bits(8'h6C, 8, rx);
        sel_off();
        chk("R8 burst write count", wr_cnt - n0, 3);
        chk("R8 burst write address", int'(wr_addr), 5);
        chk("R8 burst write last data", int'(wr_data), 8'h6C);
        chk("R3 strobe width", wr_long, 0);
    endtask

    task automatic t_burst_read();
        logic [7:0] r0, r1;
        lsb_first = 1'b1;
        sel_on();
        shift_bits(mk_cmd(1'b1, 2'b10, 5'h12), 8, r0);
        shift_bits(8'h00, 8, r0);
        shift_bits(8'h00, 8, r1);
        sel_off();
        chk("R8 burst read byte 0", int'(r0), int'(model_rd(5'h12)));
        chk("R8 burst read byte 1", int'(r1), int'(model_rd(5'h12)));
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        int n0 = wr_cnt;
        lsb_first = 1'b0;
        sel_on();
        shift_bits(mk_cmd(1'b0, 2'b00, 5'h03), 8, rx);
        shift_bits(8'hF0, 5, rx);
        sel_off();
        chk("R9 abort in data", wr_cnt - n0, 0);
        sel_on();
        shift_bits(mk_cmd(1'b0, 2'b00, 5'h09), 4, rx);
        sel_off();
        chk("R9 abort in command", wr_cnt - n0, 0);
        t_write(1'b0, 5'h09, 8'h5E, "R9 recovery");
    endtask

    initial begin
        #(400000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        #40;
        t_write(1'b0, 5'h13, 8'hC6, "R4 msb");
        t_write(1'b1, 5'h0A, 8'h3B, "R5 lsb");
        t_read(1'b0, 5'h07, "R4 msb");
        t_read(1'b1, 5'h1E, "R5 lsb");
        t_burst_write();
        t_burst_read();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule